// File: doc/BRIEF.md
# Early Incompressibility Predictor

This block watches the 32-bit tuple stream that feeds a dictionary-style compressor and makes an early guess about whether the current 4 KB unit is worth compressing. It keeps one presence bit for each of the 256 values a byte can take. It watches a single byte lane of every tuple, bits [23:16]. When a value shows up for the first time in the current unit, a running count of distinct values goes up by one.

When the 32nd tuple of a unit has been taken, the block compares the distinct count with a threshold given at an input. If the count is larger, it flags the unit as incompressible and sends a one-cycle stop command to the compressor controller. The controller can then drop the compression attempt and store the unit raw. A typical integration ties the threshold to 25. The block handles one tuple per clock and runs in lockstep with the compressor. A unit-start pulse clears all of its state in a single cycle, ready for the next unit.

Top module: `incomp_predictor`

## Requirements
- R1: After reset, decide_vld, incompressible and stop are all 0, and the presence bits and the count are empty, so a unit may follow directly with no unit_start.
- R2: Only bits [23:16] of tuple_data feed the count, and the count rises by exactly one for each lane value not yet seen in the unit. Repeated values and the other three bytes have no effect. The count saturates at its all-ones value.
- R3: decide_vld is high for exactly one cycle. That cycle is the clock cycle right after the cycle in which the 32nd accepted tuple of the unit was presented.
- R4: At the decision, incompressible becomes 1 only when the distinct count, including the 32nd tuple, is strictly greater than thresh. If the count equals thresh, incompressible is 0.
- R5: stop is a one-cycle pulse. It is high only in the decision cycle, and only when the unit is declared incompressible.
- R6: incompressible is 0 from the cycle after unit_start until the decision. It then holds the decided value until the cycle after the next unit_start.
- R7: Tuples after the 32nd of a unit are ignored. They produce no further decide_vld or stop, and they do not change incompressible.
- R8: unit_start clears all presence bits, the count and the tuple position in one cycle. A tuple presented in the same cycle as unit_start is dropped and does not count.
- R9: Cycles with tuple_vld low neither advance the tuple position nor change the count.
- R10: thresh is sampled only in the cycle that presents the 32nd tuple. Changes to thresh after that cycle do not alter the decided flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the compressor |
| rst | input | 1 | Synchronous active-high reset |
| unit_start | input | 1 | Begins a new unit and clears all state |
| tuple_vld | input | 1 | tuple_data holds a tuple this cycle |
| tuple_data | input | 32 | Current tuple; bits [23:16] are the lane that is watched |
| thresh | input | 6 | Distinct-value threshold; the count must exceed it |
| decide_vld | output | 1 | One-cycle strobe: a decision is available |
| incompressible | output | 1 | Decided flag, held until the next unit |
| stop | output | 1 | One-cycle command to abort compression |

## Verification
A unit boundary and a tuple can land in the same cycle: unit_start may arrive while tuple_vld is high. The design must clear its state and drop that tuple, not count it into the new unit. The bench provokes this at the start of most units. It drives a tuple whose lane value is not part of the unit's own pattern and sets thresh exactly equal to the true distinct count. If the dropped tuple were counted, the count would sit one above the threshold and the flag would read 1 instead of the expected 0. The same runs check that the previous unit's held flag clears in the cycle after the coincident start.

// File: rtl/incomp_pkg.sv
package incomp_pkg;

  localparam int unsigned SYM_W    = 8;
  localparam int unsigned SYM_VALS = 1 << SYM_W;

  typedef logic [SYM_W-1:0] sym_t;

  function automatic logic [15:0] sat_step(input logic [15:0] val,
                                           input logic [15:0] top,
                                           input logic        bump);
    if (bump && (val != top)) sat_step = val + 16'd1;
    else                      sat_step = val;
  endfunction

endpackage

// File: rtl/sym_presence_map.sv
module sym_presence_map
  import incomp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set_en,
  input  sym_t sel,
  output logic seen
);

  logic [SYM_VALS-1:0] map_q;

  assign seen = map_q[sel];

  generate
    for (genvar v = 0; v < SYM_VALS; v++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || clr)
          map_q[v] <= 1'b0;
        else if (set_en && (sel == sym_t'(v)))
          map_q[v] <= 1'b1;
      end
    end
  endgenerate

  AST_MAP_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (map_q == '0)); // R8

  AST_MAP_MARKED: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr) |=> map_q[$past(sel)]); // R2

endmodule

// File: rtl/distinct_counter.sv
module distinct_counter
  import incomp_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [15:0] CNT_TOP = 16'((1 << CNT_W) - 1);

  logic [15:0] stepped;

  assign stepped = sat_step(16'(cnt_q), CNT_TOP, bump);
  assign cnt_d   = clr ? '0 : stepped[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt_q >= $past(cnt_q))); // R2

  AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R2

endmodule

// File: rtl/window_tracker.sv
module window_tracker #(
  parameter int unsigned WINDOW = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic unit_start,
  input  logic tuple_vld,
  output logic accept,
  output logic last_accept
);

  localparam int unsigned TC_W = $clog2(WINDOW + 1);

  logic [TC_W-1:0] tcnt;
  logic            full;

  assign full        = (tcnt == TC_W'(WINDOW));
  assign accept      = tuple_vld && !unit_start && !full;
  assign last_accept = accept && (tcnt == TC_W'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (rst || unit_start) tcnt <= '0;
    else if (accept)       tcnt <= tcnt + TC_W'(1);
  end

  AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    tcnt <= TC_W'(WINDOW)); // R7

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tuple_vld && !unit_start) |=> (tcnt == $past(tcnt))); // R9

endmodule

// File: rtl/incomp_predictor.sv
module incomp_predictor
  import incomp_pkg::*;
#(
  parameter int unsigned TUPLE_W = 32,
  parameter int unsigned SEL_LSB = 16,
  parameter int unsigned WINDOW  = 32,
  parameter int unsigned CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               unit_start,
  input  logic               tuple_vld,
  input  logic [TUPLE_W-1:0] tuple_data,
  input  logic [CNT_W-1:0]   thresh,
  output logic               decide_vld,
  output logic               incompressible,
  output logic               stop
);

  sym_t             lane;
  logic             accept;
  logic             last_accept;
  logic             seen;
  logic             bump;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             over;

  assign lane = tuple_data[SEL_LSB +: SYM_W];
  assign bump = accept && !seen;
  assign over = cnt_d > thresh;

  window_tracker #(.WINDOW(WINDOW)) u_win (
    .clk         (clk),
    .rst         (rst),
    .unit_start  (unit_start),
    .tuple_vld   (tuple_vld),
    .accept      (accept),
    .last_accept (last_accept)
  );

  sym_presence_map u_map (
    .clk    (clk),
    .rst    (rst),
    .clr    (unit_start),
    .set_en (accept),
    .sel    (lane),
    .seen   (seen)
  );

  distinct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (unit_start),
    .bump  (bump),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      decide_vld     <= 1'b0;
      incompressible <= 1'b0;
      stop           <= 1'b0;
    end else begin
      decide_vld <= last_accept;
      stop       <= last_accept && over;
      if (unit_start)       incompressible <= 1'b0;
      else if (last_accept) incompressible <= over;
    end
  end

  AST_STOP_ONLY_ON_DECISION: assert property (@(posedge clk) disable iff (rst)
    stop |-> (decide_vld && incompressible)); // R5

  AST_DECIDE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    decide_vld |=> !decide_vld); // R3

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (!unit_start && !last_accept) |=> (incompressible == $past(incompressible))); // R6

  AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    unit_start |=> (!incompressible && !decide_vld && !stop)); // R8

  AST_COUNT_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    decide_vld |-> (cnt_q <= CNT_W'(WINDOW))); // R2

endmodule

// File: tb/test_incomp_predictor.sv
`timescale 1ns/1ps
module test_incomp_predictor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        unit_start = 1'b0;
  logic        tuple_vld = 1'b0;
  logic [31:0] tuple_data = '0;
  logic [5:0]  thresh = 6'd25;
  logic        decide_vld;
  logic        incompressible;
  logic        stop;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;

  logic [7:0] pat [40];

  always #2 clk = ~clk;

  incomp_predictor i_incomp_predictor (
    .clk            (clk),
    .rst            (rst),
    .unit_start     (unit_start),
    .tuple_vld      (tuple_vld),
    .tuple_data     (tuple_data),
    .thresh         (thresh),
    .decide_vld     (decide_vld),
    .incompressible (incompressible),
    .stop           (stop)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int distinct32();
    bit [255:0] seen = '0;
    int n = 0;
    for (int i = 0; i < 32; i++) begin
      if (!seen[pat[i]]) begin
        seen[pat[i]] = 1'b1;
        n++;
      end
    end
    return n;
  endfunction

  function automatic logic [31:0] mk_tuple(input logic [7:0] b3);
    logic [31:0] r;
    r = $urandom;
    r[23:16] = b3;
    return r;
  endfunction

  task automatic run_unit(input logic [5:0] th, input int gap_pct,
                          input bit junk_en, input logic [7:0] junk);
    int exp_cnt;
    bit exp_inc;
    exp_cnt = distinct32();
    exp_inc = (exp_cnt > int'(th));
    unit_start = 1'b1;
    tuple_vld  = junk_en;
    tuple_data = mk_tuple(junk);
    thresh     = th;
    step();
    unit_start = 1'b0;
    tuple_vld  = 1'b0;
    chk(incompressible == 1'b0, "R8 flag cleared by start", int'(incompressible), 0);
    chk(decide_vld == 1'b0 && stop == 1'b0, "R8 no strobe after start",
        int'(decide_vld), 0);
    for (int i = 0; i < 40; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        tuple_vld = 1'b0;
        step();
        chk(decide_vld == 1'b0, "R9 idle cycle gives no decision", int'(decide_vld), 0);
      end
      tuple_vld  = 1'b1;
      tuple_data = mk_tuple(pat[i]);
      step();
      tuple_vld = 1'b0;
      if (i == 31) begin
        chk(decide_vld == 1'b1, "R3 decision one cycle after tuple 32", int'(decide_vld), 1);
        chk(incompressible == exp_inc, "R4 strict compare of distinct count",
            int'(incompressible), int'(exp_inc));
        chk(stop == exp_inc, "R5 stop pulse with decision", int'(stop), int'(exp_inc));
        thresh = exp_inc ? 6'd63 : 6'd0;
      end else if (i < 31) begin
        chk(decide_vld == 1'b0, "R3 no early decision", int'(decide_vld), 0);
        chk(incompressible == 1'b0, "R6 flag low before decision", int'(incompressible), 0);
      end else begin
        chk(decide_vld == 1'b0 && stop == 1'b0, "R7 late tuple ignored",
            int'(decide_vld) + int'(stop), 0);
        chk(incompressible == exp_inc, "R10 flag held after threshold change",
            int'(incompressible), int'(exp_inc));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog expired: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(decide_vld == 0 && incompressible == 0 && stop == 0, "R1 reset state",
        int'({decide_vld, incompressible, stop}), 0);

    // R2: single lane value, other bytes random -> count 1
    for (int i = 0; i < 40; i++) pat[i] = 8'h5A;
    run_unit(6'd0, 20, 1'b1, 8'h11);
    run_unit(6'd1, 0, 1'b1, 8'h22);   // R4 equal, R8 junk would tip it

    // 32 distinct values
    for (int i = 0; i < 40; i++) pat[i] = 8'(i * 7 + 3);
    run_unit(6'd25, 10, 1'b0, 8'h00);
    run_unit(6'd32, 25, 1'b1, 8'hFF); // R4 equal at full window, R8
    run_unit(6'd31, 0, 1'b1, 8'hFE);

    // R2 map cleared between units: back to one value
    for (int i = 0; i < 40; i++) pat[i] = 8'h0A;
    run_unit(6'd0, 0, 1'b0, 8'h00);

    for (int u = 0; u < 24; u++) begin
      int k;
      int base;
      int cnt;
      k = int'($urandom_range(1, 64));
      base = int'($urandom_range(0, 255));
      for (int i = 0; i < 40; i++) pat[i] = 8'(base + int'($urandom_range(0, k - 1)));
      cnt = distinct32();
      if (u % 3 == 0) begin
        // junk lane value outside the pattern, thresh equal to true count
        logic [7:0] j;
        bit hit;
        j = 8'(base + k);
        hit = 0;
        for (int i = 0; i < 32; i++) if (pat[i] == j) hit = 1;
        run_unit(6'(cnt), 30, !hit, j);
      end else begin
        run_unit(6'($urandom_range(0, 40)), 30, u[0], 8'($urandom));
      end
    end

    report();
    $finish;
  end

endmodule